// File: doc/BRIEF.md
# SIMD Lowest-Zero Locator

This block is purely combinational. It splits a data word into equal SIMD lanes and finds, in each lane, the least significant bit that holds a zero. A lane-size selector sets the lane width for the current operation, from 8 bits up to 256 bits, in power-of-two steps. For each lane the block returns three things. The first is a prefix mask that is set from the lane's first bit up to and including the lowest zero. The second is a flag that reports a lane with no zero at all. The third is the bit position of the lowest zero inside the lane.

Increment, decrement, negate and similar units can instantiate it. Those units use the mask to decide which bits to flip, or use the flag and index directly. The AND reductions in the block are shared. Groups of 8 bits are reduced first. Pairs of groups are then combined level by level. One mux level at the end picks the grouping that matches the selected lane size. All lanes, at every size, therefore come from the same tree.

Top module: `lzf_finder`

## Requirements
- R1: Within each lane, bit i of `prefix_mask` is 1 exactly when every data bit of that lane below position i is 1. The lowest zero and all bits under it are therefore set, and every bit above it is clear.
- R2: `lane_full[k]` is 1 exactly when every data bit of lane k is 1. When it is set, the whole lane in `prefix_mask` is 1.
- R3: The index of lane k is the position of the lowest zero counted from the lane's least significant bit. It equals the lane width when the lane has no zero.
- R4: Selector code n picks lanes of 8·2^n bits. Codes 0 to 5 mean 8, 16, 32, 64, 128 and 256 bits. A code that asks for lanes wider than DATA_W, codes 6 and 7 included, gives a single lane of DATA_W bits.
- R5: Lanes are independent. Changing the data of one lane never changes the mask bits, flag or index of any other lane.
- R6: The outputs of lane k sit in slot k. That is `lane_full[k]` and `lane_index[k*IXW +: IXW]`, where IXW = clog2(DATA_W)+1. Slots numbered at or above the lane count read 0.
- R7: The outputs depend only on the present inputs. There is no clock and no stored state, so a new input is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | DATA_W | Word to scan |
| lane_sel | input | 3 | Lane size code (width = 8·2^code, capped at DATA_W) |
| prefix_mask | output | DATA_W | Per-bit mask up to and including each lane's lowest zero |
| lane_full | output | DATA_W/8 | Per-lane flag: no zero in lane |
| lane_index | output | (DATA_W/8)·(clog2(DATA_W)+1) | Per-lane position of lowest zero, packed by slot |

## Verification
The bench builds two instances of the block. One uses the default 64-bit word, where codes 4 to 7 all fall back to a single full-width lane. The other uses a 256-bit word, where every lane size from 8 to 256 bits is a real split and there are up to 32 lane slots. Both instances get the same tabulated patterns. Directed cases add all-ones and all-zero words, the capped selector codes, lanes whose zero sits in the top bit, and a lane-isolation check in which only the upper lanes change.

// File: rtl/lzf_pkg.sv
package lzf_pkg;
  // Narrowest lane; all wider lanes are built from groups of this size.
  localparam int UNIT_W = 8;
  // Width of the lane-size selector.
  localparam int SEL_W  = 3;

  typedef logic [SEL_W-1:0] lane_code_t;

  // Number of lane sizes that fit in a word of the given width.
  function automatic int level_count(input int word_w);
    return $clog2(word_w / UNIT_W) + 1;
  endfunction
endpackage

// File: rtl/lzf_unit_scan.sv
module lzf_unit_scan
  import lzf_pkg::*;
#(
  parameter int UW   = UNIT_W,
  localparam int FZW = $clog2(UW) + 1
) (
  input  logic [UW-1:0]  bits,
  output logic [UW-1:0]  pmask,
  output logic [FZW-1:0] first_zero
);

  always_comb begin
    logic run;
    run        = 1'b1;
    first_zero = FZW'(UW);
    for (int i = 0; i < UW; i++) begin
      pmask[i] = run;
      if (run && !bits[i]) first_zero = FZW'(i);
      run = run & bits[i];
    end

    // R3: a reported position inside the group really holds a zero,
    // and every bit under it is one.
    if (int'(first_zero) < UW) begin
      a_r3_unit_zero_hit: assert (!bits[int'(first_zero)])
        else $error("unit scan reports a one as first zero");
      for (int i = 0; i < UW; i++) begin
        if (i < int'(first_zero)) begin
          a_r3_unit_below_ones: assert (bits[i])
            else $error("zero below reported position");
        end
      end
    end else begin
      a_r2_unit_all_ones: assert (&bits)
        else $error("group reported full but holds a zero");
    end
    // R1: the mask never has a gap.
    for (int i = 1; i < UW; i++) begin
      a_r1_unit_mask_thermo: assert (!pmask[i] || pmask[i-1])
        else $error("unit mask not contiguous");
    end
  end

endmodule

// File: rtl/lzf_and_tree.sv
module lzf_and_tree
  import lzf_pkg::*;
#(
  parameter int DW    = 64,
  parameter int UW    = UNIT_W,
  localparam int NB   = DW / UW,
  localparam int NLVL = $clog2(NB) + 1
) (
  input  logic [DW-1:0]              data,
  output logic [NLVL-1:0][NB-1:0]    grp_ones,  // [level][group]: group all ones
  output logic [NLVL-1:0][NB-1:0]    unit_pre   // [level][unit]: lane units below all ones
);

  for (genvar L = 0; L < NLVL; L++) begin : g_lvl
    logic [NB-1:0] ones_here;
    logic [NB-1:0] pre_here;

    for (genvar g = 0; g < NB; g++) begin : g_grp
      if (L == 0) begin : g_leaf
        assign ones_here[g] = &data[g*UW +: UW];
        assign pre_here[g]  = 1'b1;
      end else begin : g_node
        localparam int H = g >> (L - 1);
        if (g < (NB >> L)) begin : g_live
          assign ones_here[g] = g_lvl[L-1].ones_here[2*g] & g_lvl[L-1].ones_here[2*g+1];
        end else begin : g_dead
          assign ones_here[g] = 1'b0;
        end
        if ((H % 2) == 1) begin : g_upper
          assign pre_here[g] = g_lvl[L-1].pre_here[g] & g_lvl[L-1].ones_here[H-1];
        end else begin : g_lower
          assign pre_here[g] = g_lvl[L-1].pre_here[g];
        end
      end
    end

    assign grp_ones[L] = ones_here;
    assign unit_pre[L] = pre_here;
  end

  // R2: a group flagged full has no zero anywhere in its span.
  always_comb begin
    for (int L = 0; L < NLVL; L++) begin
      for (int g = 0; g < NB; g++) begin
        if (grp_ones[L][g]) begin
          for (int i = 0; i < DW; i++) begin
            if ((i / UW) >> L == g) begin
              a_r2_tree_full_span: assert (data[i])
                else $error("tree flags a group full over a zero");
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/lzf_lane_select.sv
module lzf_lane_select
  import lzf_pkg::*;
#(
  parameter int DW    = 64,
  parameter int UW    = UNIT_W,
  localparam int NB   = DW / UW,
  localparam int NLVL = $clog2(NB) + 1,
  localparam int FZW  = $clog2(UW) + 1,
  localparam int IXW  = $clog2(DW) + 1
) (
  input  lane_code_t                 sel,
  input  logic [DW-1:0]              unit_mask,
  input  logic [NB-1:0][FZW-1:0]     unit_first,
  input  logic [NLVL-1:0][NB-1:0]    grp_ones,
  input  logic [NLVL-1:0][NB-1:0]    unit_pre,
  output logic [DW-1:0]              prefix_mask,
  output logic [NB-1:0]              lane_full,
  output logic [NB*IXW-1:0]          lane_index
);

  always_comb begin
    int lvl;
    int upl;
    logic [NB-1:0][IXW-1:0] acc;

    lvl = (int'(sel) > NLVL - 1) ? NLVL - 1 : int'(sel);
    upl = 1 << lvl;

    for (int i = 0; i < DW; i++) begin
      prefix_mask[i] = unit_mask[i] & unit_pre[lvl][i / UW];
    end

    lane_full = grp_ones[lvl];

    acc = '0;
    for (int b = 0; b < NB; b++) begin
      if (unit_pre[lvl][b] && !grp_ones[0][b]) begin
        acc[b >> lvl] = IXW'((b % upl) * UW + int'(unit_first[b]));
      end
    end
    for (int k = 0; k < NB; k++) begin
      if (lane_full[k]) acc[k] = IXW'(UW << lvl);
    end
    lane_index = acc;

    // Checks on the selected grouping.
    for (int k = 0; k < NB; k++) begin
      if (k < (NB >> lvl)) begin
        a_r3_index_bound: assert (int'(acc[k]) <= (UW << lvl))
          else $error("lane index beyond lane width");
        a_r1_lane_start_set: assert (prefix_mask[k * (UW << lvl)])
          else $error("lane start bit missing from mask");
        if (lane_full[k]) begin
          for (int i = 0; i < DW; i++) begin
            if (i / (UW << lvl) == k) begin
              a_r2_full_mask: assert (prefix_mask[i])
                else $error("full lane with mask hole");
            end
          end
        end
      end else begin
        a_r6_idle_slot: assert (acc[k] == '0 && !lane_full[k])
          else $error("slot beyond lane count not idle");
      end
    end
  end

endmodule

// File: rtl/lzf_finder.sv
module lzf_finder
  import lzf_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / UNIT_W,
  localparam int NLVL  = level_count(DATA_W),
  localparam int FZW   = $clog2(UNIT_W) + 1,
  localparam int IXW   = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0]  data_in,
  input  logic [SEL_W-1:0]   lane_sel,
  output logic [DATA_W-1:0]  prefix_mask,
  output logic [NB-1:0]      lane_full,
  output logic [NB*IXW-1:0]  lane_index
);

  logic [DATA_W-1:0]           unit_mask;
  logic [NB-1:0][FZW-1:0]      unit_first;
  logic [NLVL-1:0][NB-1:0]     grp_ones;
  logic [NLVL-1:0][NB-1:0]     unit_pre;

  for (genvar b = 0; b < NB; b++) begin : g_unit
    lzf_unit_scan #(.UW(UNIT_W)) scan_i (
      .bits       (data_in[b*UNIT_W +: UNIT_W]),
      .pmask      (unit_mask[b*UNIT_W +: UNIT_W]),
      .first_zero (unit_first[b])
    );
  end

  lzf_and_tree #(.DW(DATA_W), .UW(UNIT_W)) tree_i (
    .data     (data_in),
    .grp_ones (grp_ones),
    .unit_pre (unit_pre)
  );

  lzf_lane_select #(.DW(DATA_W), .UW(UNIT_W)) pick_i (
    .sel         (lane_code_t'(lane_sel)),
    .unit_mask   (unit_mask),
    .unit_first  (unit_first),
    .grp_ones    (grp_ones),
    .unit_pre    (unit_pre),
    .prefix_mask (prefix_mask),
    .lane_full   (lane_full),
    .lane_index  (lane_index)
  );

endmodule

// File: tb/lzf_finder_tb_top.sv
module lzf_finder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0]  d_n;
  logic [2:0]   s_n;
  logic [63:0]  mask_n;
  logic [7:0]   full_n;
  logic [55:0]  idx_n;

  logic [255:0] d_w;
  logic [2:0]   s_w;
  logic [255:0] mask_w;
  logic [31:0]  full_w;
  logic [287:0] idx_w;

  lzf_finder #(.DATA_W(64)) dut_i (
    .data_in(d_n), .lane_sel(s_n), .prefix_mask(mask_n),
    .lane_full(full_n), .lane_index(idx_n));

  lzf_finder #(.DATA_W(256)) dut_wide_i (
    .data_in(d_w), .lane_sel(s_w), .prefix_mask(mask_w),
    .lane_full(full_w), .lane_index(idx_w));

  localparam logic [66:0] VEC [12] = '{
    {3'd0, 64'h00FF_7F80_0103_FFFE},
    {3'd0, 64'hFFFF_FFFF_FFFF_FFFF},
    {3'd1, 64'h7FFF_FFFF_00FF_8001},
    {3'd1, 64'h1234_5678_9ABC_DEF0},
    {3'd2, 64'hFFFF_7FFF_0000_FFFF},
    {3'd2, 64'h8000_0000_FFFF_FFFE},
    {3'd3, 64'h7FFF_FFFF_FFFF_FFFF},
    {3'd3, 64'hFFFF_FFFF_FFEF_FFFF},
    {3'd4, 64'h0F0F_F0F0_FFFF_00FF},
    {3'd5, 64'hFFFF_FFFE_FFFF_FFFF},
    {3'd6, 64'hDEAD_BEEF_FFFF_FFFF},
    {3'd7, 64'h0000_0000_0000_0000}
  };

  // Expected outputs from the requirements: lane width 8<<sel capped at w.
  function automatic void model(input int w, input logic [255:0] d, input int sel,
                                output logic [255:0] m, output logic [31:0] f,
                                output logic [287:0] ix, input int ixw);
    int lw, nl, pos;
    bit seen;
    lw = 8 << sel;
    if (lw > w) lw = w;
    nl = w / lw;
    m = '0; f = '0; ix = '0;
    for (int k = 0; k < nl; k++) begin
      seen = 1'b0;
      pos  = lw;
      for (int b = 0; b < lw; b++) begin
        if (!seen) m[k*lw + b] = 1'b1;
        if (!seen && !d[k*lw + b]) begin
          seen = 1'b1;
          pos  = b;
        end
      end
      f[k] = !seen;
      for (int j = 0; j < ixw; j++) ix[k*ixw + j] = pos[j];
    end
  endfunction

  task automatic chk(input string tag, input logic [287:0] act, input logic [287:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive after the rising edge, compare at the falling edge (R7: same cycle).
  task automatic apply(input logic [63:0] dn, input logic [255:0] dw, input logic [2:0] s,
                       input string tag);
    logic [255:0] em;
    logic [31:0]  ef;
    logic [287:0] ei;
    @(posedge clk);
    #1;
    d_n = dn; s_n = s; d_w = dw; s_w = s;
    @(negedge clk);
    model(64, {192'b0, dn}, int'(s), em, ef, ei, 7);
    chk({"R1 mask64 ", tag},  {224'b0, mask_n}, {224'b0, em[63:0]});
    chk({"R2 full64 ", tag},  {280'b0, full_n}, {280'b0, ef[7:0]});
    chk({"R3 index64 ", tag}, {232'b0, idx_n},  {232'b0, ei[55:0]});
    model(256, dw, int'(s), em, ef, ei, 9);
    chk({"R1 mask256 ", tag},  {32'b0, mask_w},  {32'b0, em});
    chk({"R2 full256 ", tag},  {256'b0, full_w}, {256'b0, ef});
    chk({"R3 index256 ", tag}, idx_w, ei);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0]  keep_m;
    logic [6:0]   keep_i;
    logic         keep_f;
    d_n = '0; s_n = '0; d_w = '0; s_w = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Inputs at their reset values: each 8-bit lane stops at its first bit.
    chk("R1 reset mask",  {224'b0, mask_n}, {224'b0, 64'h0101_0101_0101_0101});
    chk("R2 reset full",  {280'b0, full_n}, 288'b0);
    chk("R3 reset index", {232'b0, idx_n},  288'b0);

    for (int v = 0; v < 12; v++) begin
      logic [63:0] dv;
      dv = VEC[v][63:0];
      apply(dv, {~dv, dv ^ {8{8'hA5}}, dv, {dv[31:0], dv[63:32]}}, VEC[v][66:64], "R4 table");
    end

    // R4: codes beyond the word width behave as one full-width lane.
    apply(64'hFFFF_FFFF_FFFF_FFFF, {256{1'b1}}, 3'd5, "R4 full word");
    chk("R4 capped index64", {281'b0, idx_n[6:0]}, {281'b0, 7'd64});
    apply(64'h7FFF_FFFF_FFFF_FFFF, {1'b0, {255{1'b1}}}, 3'd7, "R4 top-bit zero");
    chk("R4 capped top zero", {279'b0, idx_w[8:0]}, {279'b0, 9'd255});

    // R6: with one lane, only slot 0 carries a result.
    apply(64'hFFFF_FFFF_FFFF_FFFF, {256{1'b1}}, 3'd3, "R6 one lane");
    chk("R6 idle slots", {239'b0, idx_n[55:7]}, 288'b0);
    chk("R6 full slot0 only", {280'b0, full_n}, {280'b0, 8'h01});

    // R5: only upper lanes change; lane 0 (16 bits) must not move.
    apply(64'h0000_0000_0000_03FF, {256{1'b0}}, 3'd1, "R5 base");
    keep_m = mask_n; keep_f = full_n[0]; keep_i = idx_n[6:0];
    apply(64'hFFFF_FFFF_FFFF_03FF, {256{1'b1}}, 3'd1, "R5 upper flip");
    chk("R5 lane0 mask",  {272'b0, mask_n[15:0]}, {272'b0, keep_m[15:0]});
    chk("R5 lane0 flag",  {287'b0, full_n[0]},    {287'b0, keep_f});
    chk("R5 lane0 index", {281'b0, idx_n[6:0]},   {281'b0, keep_i});
    chk("R5 lane0 index value", {281'b0, idx_n[6:0]}, {281'b0, 7'd10});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule